// File: doc/BRIEF.md
# Serial Management Bus Master (Clause 22)

This block reads and writes 16-bit PHY registers over the two-wire management bus. It generates the management clock (MDC) by dividing the system clock. It also drives or releases the bidirectional data line (MDIO) through a separate data output and output-enable pair. A host hands over one request at a time: a direction flag, a 5-bit PHY address, a register address and, for writes, 16 bits of data. When the frame has finished on the wire, the block answers with a one-cycle completion pulse and the register value it read.

The request side is a valid/ready stream.
- A request transfers on a clock edge where both `req_valid` and `req_ready` are high.
- `req_ready` is low for the whole of a frame in progress. During that time the request fields may change freely and nothing is taken.
- A host that wants back-to-back frames holds `req_valid` high. The next request then transfers in the same cycle as the completion pulse of the previous one.

The response side has no back-pressure. The completion pulse and the read data are plain status.

Requests whose register address lies outside the 5-bit range are answered without touching the bus.

Top module: `mdio_master`

## Requirements
- R1: `req_ready` is high exactly when no frame is in progress. A request transfers when `req_valid` and `req_ready` are both high at a rising clock edge. While a frame runs, `req_valid` and the request fields have no effect on the wires, on the completion pulse or on the read data.
- R2: MDC is low while idle. During a frame, each low half and each high half of MDC lasts `HALF_CYC` system clocks. With the default of 40 at 200 MHz, this gives 2.5 MHz.
- R3: Every frame opens with 33 MDC periods in which MDIO is driven to 1.
- R4: A read then drives 14 bits, most significant first: `01`, `10`, the PHY address (5 bits), then the register address (5 bits).
- R5: After the read command, MDIO is released for 19 MDC periods. MDIO is sampled in the last system clock of each low half. The read result is the 2nd through 17th of these samples, counting from zero after the first, with the first of the sixteen as bit 15. The result appears with the completion pulse.
- R6: A write drives 32 bits, most significant first: `01`, `01`, the PHY address, the register address, `10`, then the 16 data bits.
- R7: After the 32 write bits, MDIO is released for two further MDC periods before completion.
- R8: A request whose register address is above 31 produces no MDC edge and no MDIO drive. Its completion pulse comes in the cycle after transfer. A read answered this way returns 0xFFFF. A write answered this way leaves the read data unchanged.
- R9: MDIO data and enable change only when MDC falls (or at frame start while MDC is low). They are constant throughout each high half.
- R10: The completion pulse is one cycle long and comes in the cycle `req_ready` returns high. MDIO is undriven while idle. After reset, the outputs are idle and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | REG_AW | Register address; values above 31 are rejected |
| req_wdata | input | 16 | Data for writes |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last read result |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO level on the wire |

## Verification
Two events can share a cycle: the completion of one frame, and the transfer of the next request. The bench offers a second request immediately after the first transfers and holds `req_valid` high. That request is then taken in exactly the cycle the completion pulse is high. A cycle-accurate model then expects the previous read data on that pulse and a fresh preamble starting on the next edge. The same stream comparison covers requests offered in the middle of a frame. These include out-of-range register addresses, which must leave the running frame untouched.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int PRE_BITS   = 33;
  localparam int RD_CMD     = 14;
  localparam int RD_RX      = 19;
  localparam int WR_FRAME   = 32;
  localparam int WR_TAIL    = 2;
  localparam int RD_TOTAL   = PRE_BITS + RD_CMD + RD_RX;
  localparam int WR_TOTAL   = PRE_BITS + WR_FRAME + WR_TAIL;
  localparam int IDX_W      = $clog2(WR_TOTAL + 1);

  typedef struct packed {
    logic oe;
    logic d;
  } drv_t;

  // Drive state of MDIO for bit slot idx of a frame.
  function automatic drv_t frame_bit(input logic wr, input logic [4:0] phy,
                                     input logic [4:0] ra, input logic [15:0] wd,
                                     input int idx);
    logic [31:0] wf;
    logic [13:0] rf;
    drv_t r;
    wf = {2'b01, 2'b01, phy, ra, 2'b10, wd};
    rf = {2'b01, 2'b10, phy, ra};
    r.oe = 1'b1;
    r.d  = 1'b1;
    if (idx >= PRE_BITS) begin
      if (wr) begin
        if (idx < PRE_BITS + WR_FRAME) begin
          wf = wf << (idx - PRE_BITS);
          r.d = wf[31];
        end else begin
          r.oe = 1'b0;
        end
      end else begin
        if (idx < PRE_BITS + RD_CMD) begin
          rf = rf << (idx - PRE_BITS);
          r.d = rf[13];
        end else begin
          r.oe = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic is_rx_slot(input logic wr, input int idx);
    return !wr && (idx >= PRE_BITS + RD_CMD);
  endfunction
endpackage

// File: rtl/mdio_tick.sv
`timescale 1ns/1ps
module mdio_tick #(
  parameter int HALF_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_end
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign half_end = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (half_end) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mdio_seq.sv
`timescale 1ns/1ps
module mdio_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc,
  input  logic        wr_in,
  input  logic [4:0]  phy_in,
  input  logic [4:0]  ra_in,
  input  logic [15:0] wd_in,
  input  logic        half_end,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        sample_en,
  output logic        ending_rd,
  output logic        fin
);
  logic [IDX_W-1:0] idx;
  logic             l_wr;
  logic [4:0]       l_phy, l_ra;
  logic [15:0]      l_wd;
  logic             ending;
  int               last_idx;
  drv_t             nxt;

  always_comb begin
    last_idx  = l_wr ? WR_TOTAL - 1 : RD_TOTAL - 1;
    ending    = busy && half_end && mdc && (int'(idx) == last_idx);
    ending_rd = ending && !l_wr;
    sample_en = busy && half_end && !mdc && is_rx_slot(l_wr, int'(idx));
    nxt       = frame_bit(l_wr, l_phy, l_ra, l_wd, int'(idx) + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      mdc     <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      fin     <= 1'b0;
      idx     <= '0;
      l_wr    <= 1'b0;
      l_phy   <= '0;
      l_ra    <= '0;
      l_wd    <= '0;
    end else begin
      fin <= 1'b0;
      if (acc) begin
        busy  <= 1'b1;
        mdc   <= 1'b0;
        idx   <= '0;
        l_wr  <= wr_in;
        l_phy <= phy_in;
        l_ra  <= ra_in;
        l_wd  <= wd_in;
        {mdio_oe, mdio_o} <= frame_bit(wr_in, phy_in, ra_in, wd_in, 0);
      end else if (busy && half_end) begin
        if (!mdc) begin
          mdc <= 1'b1;
        end else begin
          mdc <= 1'b0;
          if (ending) begin
            busy    <= 1'b0;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
            fin     <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            {mdio_oe, mdio_o} <= nxt;
          end
        end
      end
    end
  end

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
  assert_hold_in_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mdc) |-> $stable({mdio_oe, mdio_o}));
  assert_sample_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> !mdio_oe);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/mdio_rxcap.sv
`timescale 1ns/1ps
module mdio_rxcap
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_en,
  input  logic        mdio_i,
  input  logic        load_cap,
  input  logic        load_ones,
  output logic [15:0] rdata
);
  logic [RD_RX-1:0] samp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp  <= '0;
      rdata <= '0;
    end else begin
      if (sample_en) samp <= {samp[RD_RX-2:0], mdio_i};
      if (load_ones)     rdata <= 16'hFFFF;
      else if (load_cap) rdata <= samp[16:1];
    end
  end

  assert_single_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_cap && load_ones));
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master #(
  parameter int HALF_CYC = 40,
  parameter int REG_AW   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [4:0]        req_phy,
  input  logic [REG_AW-1:0] req_reg,
  input  logic [15:0]       req_wdata,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  output logic              busy,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic oor, take, acc, rej, rej_q;
  logic half_end, sample_en, ending_rd, fin;

  generate
    if (REG_AW > 5) begin : g_wide
      assign oor = |req_reg[REG_AW-1:5];
    end else begin : g_narrow
      assign oor = 1'b0;
    end
  endgenerate

  assign req_ready = !busy;
  assign take      = req_valid && req_ready;
  assign acc       = take && !oor;
  assign rej       = take && oor;
  assign rsp_done  = fin || rej_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rej_q <= 1'b0;
    else        rej_q <= rej;
  end

  mdio_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_end(half_end)
  );

  mdio_seq u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wr_in(req_write),
    .phy_in(req_phy), .ra_in(req_reg[4:0]), .wd_in(req_wdata),
    .half_end(half_end), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .sample_en(sample_en), .ending_rd(ending_rd), .fin(fin)
  );

  mdio_rxcap u_rx (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .mdio_i(mdio_i),
    .load_cap(ending_rd), .load_ones(rej && !req_write), .rdata(rsp_rdata)
  );

  assert_accept_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (busy && !req_ready));
  assert_reject_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rej |=> (rsp_done && !busy && !mdc && !mdio_oe));
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int HALF = 4;
  localparam int AW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [4:0] req_phy = '0;
  logic [AW-1:0] req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic mdio_i = 1'b1;
  logic req_ready, rsp_done, busy, mdc, mdio_o, mdio_oe;
  logic [15:0] rsp_rdata;

  always #2.5 clk = ~clk;

  mdio_master #(.HALF_CYC(HALF), .REG_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct {
    bit busy; bit mdc; bit oe; bit o; bit done;
    logic [15:0] rd;
    int tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int checks = 0, errors = 0, cycles = 0, rises = 0;
  bit started = 0, mdc_prev = 0, cur_rd = 0;
  logic [15:0] shadow_rd = '0;
  logic [15:0] phy_pending = '0;
  logic [18:0] phy_bits = '1;

  function automatic string rq(input int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string r, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s cycle %0d actual %0h expected %0h", r, what, cycles, act, exp);
    end
  endtask

  // Append the expected cycles of one bit slot (low half then high half).
  function automatic void push_slot(input bit oe, input bit o, input int tag);
    exp_t x;
    for (int h = 0; h < 2 * HALF; h++) begin
      x.busy = 1; x.mdc = (h >= HALF); x.oe = oe; x.o = o; x.done = 0;
      x.rd = shadow_rd; x.tag = tag;
      q.push_back(x);
    end
  endfunction

  function automatic void push_request(input bit wr, input logic [4:0] phy,
                                       input logic [AW-1:0] ra, input logic [15:0] wd,
                                       input logic [15:0] resp);
    exp_t x;
    logic [31:0] wf;
    logic [13:0] rf;
    if (ra > 31) begin               // R8: answered without bus activity
      if (!wr) shadow_rd = 16'hFFFF;
      x.busy = 0; x.mdc = 0; x.oe = 0; x.o = 1; x.done = 1; x.rd = shadow_rd; x.tag = 8;
      q.push_back(x);
      return;
    end
    for (int i = 0; i < 33; i++) push_slot(1, 1, 3);          // R3 preamble
    if (wr) begin
      wf = {2'b01, 2'b01, phy, ra[4:0], 2'b10, wd};          // R6 layout
      for (int i = 31; i >= 0; i--) push_slot(1, wf[i], 6);
      for (int i = 0; i < 2; i++) push_slot(0, 1, 7);        // R7 tail
    end else begin
      rf = {2'b01, 2'b10, phy, ra[4:0]};                     // R4 layout
      for (int i = 13; i >= 0; i--) push_slot(1, rf[i], 4);
      for (int i = 0; i < 19; i++) push_slot(0, 1, 5);       // R5 released
      shadow_rd = resp;
    end
    x.busy = 0; x.mdc = 0; x.oe = 0; x.o = 1; x.done = 1; x.rd = shadow_rd; x.tag = 10;
    q.push_back(x);
  endfunction

  // Reference model and PHY, evaluated at the falling clock edge.
  always @(negedge clk) begin
    if (started) begin
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
      if (mdc && !mdc_prev) rises++;
      mdc_prev = mdc;
      if (cur_rd && rises >= 47 && rises <= 65) mdio_i = phy_bits[18 - (rises - 47)];
      else mdio_i = 1'b1;

      if (q.size() > 0) e = q.pop_front();
      else begin
        e.busy = 0; e.mdc = 0; e.oe = 0; e.o = 1; e.done = 0; e.rd = shadow_rd; e.tag = 10;
      end
      chk(busy == e.busy, rq(e.tag), "busy", busy, e.busy);
      chk(req_ready == !e.busy, "R1", "req_ready", req_ready, !e.busy);
      chk(mdc == e.mdc, "R2", "mdc", mdc, e.mdc);
      chk(mdio_oe == e.oe, rq(e.tag), "mdio_oe", mdio_oe, e.oe);
      if (e.oe) chk(mdio_o == e.o, rq(e.tag), "mdio_o", mdio_o, e.o);
      chk(rsp_done == e.done, "R10", "rsp_done", rsp_done, e.done);
      chk(rsp_rdata == e.rd, rq(e.tag == 8 ? 8 : 5), "rsp_rdata", rsp_rdata, e.rd);

      if (req_valid && req_ready) begin
        rises = 0; mdc_prev = 0;
        cur_rd = !req_write;
        phy_bits = {1'b1, 1'b0, phy_pending, 1'b1};
        push_request(req_write, req_phy, req_reg, req_wdata, phy_pending);
      end
    end
  end

  task automatic issue(input bit wr, input logic [4:0] phy, input logic [AW-1:0] ra,
                       input logic [15:0] wd, input logic [15:0] resp);
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_phy = phy; req_reg = ra; req_wdata = wd;
    phy_pending = resp;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  // R1: offers while a frame runs must be ignored.
  task automatic poke();
    repeat (20) @(posedge clk);
    #1;
    req_valid = 1; req_write = 1; req_phy = 5'h1F; req_reg = 6'd45; req_wdata = 16'hDEAD;
    repeat (3) @(posedge clk);
    #1;
    req_reg = 6'd3;
    repeat (3) @(posedge clk);
    #1;
    req_valid = 0;
  endtask

  task automatic wait_idle();
    do begin
      @(posedge clk); #1;
    end while (busy || q.size() != 0);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk(!busy && !mdc && !mdio_oe && !rsp_done && req_ready, "R10", "reset outputs",
        {busy, mdc, mdio_oe, rsp_done, req_ready}, 5'b00001);
    chk(rsp_rdata == 16'h0, "R10", "reset rdata", rsp_rdata, 0);
    started = 1;

    issue(0, 5'd5, 6'd2, 16'h0, 16'hA5C3);   wait_idle();   // R4 R5
    issue(1, 5'd31, 6'd0, 16'h1234, 16'h0);  wait_idle();   // R6 R7
    issue(0, 5'd0, 6'd31, 16'h0, 16'h0001);  wait_idle();   // R5 low bit
    issue(0, 5'd9, 6'd40, 16'h0, 16'h0);     wait_idle();   // R8 read reject
    issue(1, 5'd9, 6'd63, 16'hBEEF, 16'h0);  wait_idle();   // R8 write reject
    issue(0, 5'd12, 6'd7, 16'h0, 16'h8000);                 // done and next take share a cycle
    issue(1, 5'd3, 6'd16, 16'hFFFF, 16'h0);  wait_idle();
    issue(0, 5'd21, 6'd1, 16'h0, 16'h5A5A);  poke(); wait_idle();   // R1
    issue(1, 5'd10, 6'd17, 16'h0000, 16'h0); wait_idle();   // R6 zero data
    issue(0, 5'd1, 6'd30, 16'h0, 16'hFFFE);  wait_idle();   // R9 via stream
    repeat (5) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule